// File: doc/BRIEF.md
# Double-Buffered Bidirectional I/O Latch

This block is the data path behind a bank of bidirectional digital lines. A host writes a value into an internal output latch, which it can always read back. A second latch drives the pins. An input register captures the pin levels. An output-enable register, active low, sets each line's tri-state driver. Lines whose enable bit is 1 are left undriven and act as inputs.

A two-bit control register picks the clock for the pin latch and the input register. With double buffering off, both update on every falling edge of the system clock. With it on, both update only on the selected edge of an external strobe. One strobe edge moves all outputs to the pins and samples all inputs together. The strobe is synchronized into the system clock domain and edge-detected there. It is expected to run at 1 MHz or less.

Top module: `dbio_latch`

## Requirements
- R1: After reset, the output-enable register reads all ones and `pin_oen_o` is all ones. The control register, the internal latch, `pin_o` and the input register all read 0.
- R2: A write to address 2 (output enable) appears on `pin_oen_o` after the next rising clock edge. Bit value 0 means the line is driven and 1 means high impedance. Reading address 2 returns the register.
- R3: A write to address 3 (control) stores bit 0 (double-buffer enable) and bit 1 (strobe edge: 0 rising, 1 falling). Reading address 3 returns those two bits, and every higher bit reads 0.
- R4: Reading address 0 returns the internal latch, meaning the last value written to address 0. This holds even while the pins still show an older value.
- R5: With double buffering off, `pin_o` takes the internal latch value at the falling clock edge after the rising edge that loaded it. That is within the same clock cycle as the write.
- R6: Reading address 1 returns the input register. With double buffering off, the register captures `pin_i` at every falling clock edge.
- R7: With double buffering on and the edge bit at 0, `pin_o` and the input register hold their values until a rising edge of `strobe_i`. That edge updates both, within three clock cycles. A falling strobe edge updates neither.
- R8: With double buffering on and the edge bit at 1, only a falling edge of `strobe_i` updates `pin_o` and the input register.
- R9: Writes to address 1 have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe, sampled on the rising clock edge |
| addr_i | input | 2 | Register address: 0 output latch, 1 direct read, 2 output enable, 3 control |
| wdata_i | input | 24 | Write data, one bit per line |
| rdata_o | output | 24 | Read data for `addr_i`, combinational |
| pin_i | input | 24 | Line levels seen at the pins |
| pin_o | output | 24 | Values driven onto the lines |
| pin_oen_o | output | 24 | Per-line driver enable, 0 drives |
| strobe_i | input | 1 | External update strobe for double buffering |

## Verification
Walking-one and walking-zero patterns, plus alternating patterns, sweep the output latch, the input register and the enable register. These patterns expose any swapped or stuck bit and any wrong active level on the enables. Each double-buffer mode is run with strobe edges of both polarities. This separates an update taken on the selected edge from one taken on the wrong edge, and from an update that ignores the strobe entirely. The bench also compares read-back against pin output during the window before a strobe. This tells the internal latch apart from the pin latch. A write to the read-only address checks that nothing is disturbed.

// File: rtl/dbio_pkg.sv
package dbio_pkg;
  typedef enum logic [1:0] {
    A_OUT  = 2'd0,
    A_IN   = 2'd1,
    A_OEN  = 2'd2,
    A_CTRL = 2'd3
  } addr_e;

  typedef struct packed {
    logic edge_fall;
    logic dbl_en;
  } ctrl_t;
endpackage

// File: rtl/dbio_regs.sv
module dbio_regs
  import dbio_pkg::*;
#(
  parameter int W = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    addr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [W-1:0]  in_reg_i,
  output logic [W-1:0]  rdata_o,
  output logic [W-1:0]  out_latch_o,
  output logic [W-1:0]  oen_o,
  output ctrl_t         ctrl_o
);
  localparam int CW = $bits(ctrl_t);

  logic [W-1:0] out_q, oen_q;
  ctrl_t        ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      oen_q  <= '1;
      ctrl_q <= '0;
    end else if (wr_en_i) begin
      unique case (addr_e'(addr_i))
        A_OUT:   out_q  <= wdata_i;
        A_OEN:   oen_q  <= wdata_i;
        A_CTRL:  ctrl_q <= ctrl_t'(wdata_i[CW-1:0]);
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (addr_e'(addr_i))
      A_OUT:   rdata_o = out_q;
      A_IN:    rdata_o = in_reg_i;
      A_OEN:   rdata_o = oen_q;
      default: rdata_o = {{(W-CW){1'b0}}, ctrl_q};
    endcase
  end

  assign out_latch_o = out_q;
  assign oen_o       = oen_q;
  assign ctrl_o      = ctrl_q;
endmodule

// File: rtl/dbio_strobe.sv
module dbio_strobe
  import dbio_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  strobe_i,
  input  ctrl_t ctrl_i,
  output logic  upd_o
);
  localparam int SW = SYNC + 1;

  logic [SW-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SW-2:0], strobe_i};
  end

  logic cur, prev, hit;
  assign cur  = sh_q[SW-2];
  assign prev = sh_q[SW-1];
  assign hit  = ctrl_i.edge_fall ? (prev & ~cur) : (cur & ~prev);
  // without double buffering the pin side updates every falling clock edge
  assign upd_o = ctrl_i.dbl_en ? hit : 1'b1;
endmodule

// File: rtl/dbio_pins.sv
module dbio_pins #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         upd_i,
  input  logic [W-1:0] out_latch_i,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] in_reg_o
);
  // half cycle after the host-side rising edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_o    <= '0;
      in_reg_o <= '0;
    end else if (upd_i) begin
      pin_o    <= out_latch_i;
      in_reg_o <= pin_i;
    end
  end
endmodule

// File: rtl/dbio_latch.sv
module dbio_latch
  import dbio_pkg::*;
#(
  parameter int W    = 24,
  parameter int SYNC = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] pin_oen_o,
  input  logic         strobe_i
);
  logic [W-1:0] out_latch, in_reg;
  ctrl_t        ctrl;
  logic         upd;

  dbio_regs #(.W(W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .in_reg_i    (in_reg),
    .rdata_o     (rdata_o),
    .out_latch_o (out_latch),
    .oen_o       (pin_oen_o),
    .ctrl_o      (ctrl)
  );

  dbio_strobe #(.SYNC(SYNC)) u_strobe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe_i),
    .ctrl_i   (ctrl),
    .upd_o    (upd)
  );

  dbio_pins #(.W(W)) u_pins (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .upd_i       (upd),
    .out_latch_i (out_latch),
    .pin_i       (pin_i),
    .pin_o       (pin_o),
    .in_reg_o    (in_reg)
  );
endmodule

// File: rtl/dbio_latch_chk.sv
module dbio_latch_chk #(
  parameter int W = 24
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         wr_en_i,
  input logic [1:0]   addr_i,
  input logic [W-1:0] wdata_i,
  input logic [W-1:0] rdata_o,
  input logic [W-1:0] pin_o,
  input logic [W-1:0] pin_oen_o,
  input logic [W-1:0] out_latch,
  input logic         upd
);
  p_oen_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd2) |=> (pin_oen_o == $past(wdata_i)));

  p_ctrl_rsvd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 2'd3) |-> (rdata_o[W-1:2] == '0));

  p_readback_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd0) |=> (addr_i != 2'd0 || rdata_o == $past(wdata_i)));

  p_pin_follow_r5: assert property (@(negedge clk_i) disable iff (!rst_ni)
    upd |=> (pin_o == $past(out_latch)));

  p_pin_hold_r7: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !upd |=> $stable(pin_o));

  p_oen_ro_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd1) |=> $stable(pin_oen_o));
endmodule

bind dbio_latch dbio_latch_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .pin_o     (pin_o),
  .pin_oen_o (pin_oen_o),
  .out_latch (out_latch),
  .upd       (upd)
);

// File: tb/dbio_latch_bench.sv
module dbio_latch_bench;
  localparam int W   = 24;
  localparam int CLK = 10;

  logic         clk = 0, rst_ni = 0, wr_en = 0, strobe = 0;
  logic [1:0]   addr = 0;
  logic [W-1:0] wdata = 0, pin_in = 0;
  logic [W-1:0] rdata, pin_out, pin_oen;
  int total = 0, bad = 0;
  logic done = 0;

  always #(CLK/2) clk = ~clk;

  dbio_latch u_dbio_latch (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin_in), .pin_o(pin_out),
    .pin_oen_o(pin_oen), .strobe_i(strobe)
  );

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // write occurs on the next rising edge; returns at posedge+1
  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; wr_en = 1;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [W-1:0] d);
    addr = a; #1; d = rdata;
  endtask

  // advance to just before a rising edge, after the falling edge
  task automatic settle(int n);
    repeat (n) @(posedge clk);
    #(CLK - 2);
  endtask

  task automatic set_strobe(logic v);
    @(posedge clk); #1; strobe = v;
  endtask

  logic [W-1:0] v;

  initial begin
    #(CLK * 3000);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    rd(2'd2, v); chk("R1 oen reg", v, '1);
    chk("R1 pin_oen_o", pin_oen, '1);
    rd(2'd3, v); chk("R1 ctrl", v, '0);
    rd(2'd0, v); chk("R1 latch", v, '0);
    chk("R1 pin_o", pin_out, '0);
    rd(2'd1, v); chk("R1 input reg", v, '0);
    rst_ni = 1;

    // R2 output enable walking zero
    for (int i = 0; i < W; i++) begin
      wr(2'd2, ~(W'(1) << i));
      chk("R2 pin_oen_o", pin_oen, ~(W'(1) << i));
    end
    wr(2'd2, 24'h5A5A5A);
    rd(2'd2, v); chk("R2 oen readback", v, 24'h5A5A5A);

    // R3 control fields and reserved bits
    for (int c = 0; c < 4; c++) begin
      wr(2'd3, {22'h3FFFFC >> 0, 2'(c)} | 24'hFFFFFC);
      rd(2'd3, v); chk("R3 ctrl readback", v, W'(c));
    end
    wr(2'd3, '0);

    // R4 R5 single-buffer output walking one
    for (int i = 0; i < W; i++) begin
      wr(2'd0, W'(1) << i);
      #3; // before the falling edge of this cycle
      rd(2'd0, v); chk("R4 readback", v, W'(1) << i);
      #3; // after falling edge
      chk("R5 pin_o same cycle", pin_out, W'(1) << i);
    end
    wr(2'd0, 24'hA5C33C);
    settle(1);
    chk("R5 pin_o pattern", pin_out, 24'hA5C33C);

    // R6 input register walking one
    for (int i = 0; i < W; i++) begin
      @(posedge clk); #1; pin_in = W'(1) << i;
      settle(0); // waits past falling edge
      rd(2'd1, v); chk("R6 direct read", v, W'(1) << i);
    end
    @(posedge clk); #1; pin_in = 24'h0F0F0F;
    settle(0);
    rd(2'd1, v); chk("R6 direct read pattern", v, 24'h0F0F0F);

    // R9 write to read-only address
    wr(2'd1, 24'hFFFFFF);
    settle(1);
    rd(2'd0, v); chk("R9 latch kept", v, 24'hA5C33C);
    rd(2'd2, v); chk("R9 oen kept", v, 24'h5A5A5A);
    rd(2'd3, v); chk("R9 ctrl kept", v, '0);
    rd(2'd1, v); chk("R9 input kept", v, 24'h0F0F0F);

    // R7 double buffering on rising strobe edge
    wr(2'd3, 24'h1);
    wr(2'd0, 24'h123456);
    @(posedge clk); #1; pin_in = 24'hFEDCBA;
    settle(4);
    chk("R7 pin_o held", pin_out, 24'hA5C33C);
    rd(2'd1, v); chk("R7 input held", v, 24'h0F0F0F);
    rd(2'd0, v); chk("R4 readback before strobe", v, 24'h123456);
    set_strobe(1);
    settle(3);
    chk("R7 pin_o on rise", pin_out, 24'h123456);
    rd(2'd1, v); chk("R7 input on rise", v, 24'hFEDCBA);
    wr(2'd0, 24'h00FF00);
    @(posedge clk); #1; pin_in = 24'h111111;
    set_strobe(0);
    settle(4);
    chk("R7 fall ignored pin_o", pin_out, 24'h123456);
    rd(2'd1, v); chk("R7 fall ignored input", v, 24'hFEDCBA);

    // R8 falling edge selected
    wr(2'd3, 24'h3);
    set_strobe(1);
    settle(4);
    chk("R8 rise ignored pin_o", pin_out, 24'h123456);
    rd(2'd1, v); chk("R8 rise ignored input", v, 24'hFEDCBA);
    set_strobe(0);
    settle(3);
    chk("R8 pin_o on fall", pin_out, 24'h00FF00);
    rd(2'd1, v); chk("R8 input on fall", v, 24'h111111);

    // back to single buffering: updates resume
    wr(2'd3, 24'h0);
    settle(1);
    chk("R5 resume", pin_out, 24'h00FF00);
    wr(2'd0, 24'h777777);
    settle(0);
    chk("R5 resume write", pin_out, 24'h777777);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule